// File: doc/BRIEF.md
# Converter Fault Hiccup Controller

This block is the digital protection sequencer for a group of synchronous buck converter channels. Each channel has its own state machine. The design clock is the PWM clock, so every rising edge closes one switching cycle. At that edge the block samples the comparator results for the cycle that just ended: overcurrent (sensed while the high-side switch conducted), undervoltage and overvoltage. It also samples a soft-start-complete flag from the ramp sequencer and an external channel-off flag.

Two outputs act at once, with no register in the path. The first is a request to cut the high-side pulse short. The second is a request to hold the low-side switch on. The block also counts runs of consecutive fault cycles. A long enough run of overcurrent or undervoltage produces a one-cycle hiccup pulse, which tells the sequencer to discharge the soft-start ramp and restart it. A long enough run of overvoltage instead latches both gates of the channel into high impedance. That latch is released by the channel-off flag, by reset (power recycle), or by a run of undervoltage cycles, which also fires a hiccup.

Top module: `fault_hiccup_ctl`

## Requirements
- R1: `pulse_cut[i]` equals `oc_hit[i]` in the same cycle, with no clock delay, whether or not soft-start is complete.
- R2: With the channel armed, OC_LIM (32) consecutive overcurrent cycles raise `hiccup[i]` in the cycle after the edge that sampled the last of them. A cycle without overcurrent restarts the count from zero.
- R3: While `ss_done[i]` is low and the channel is not latched, the overcurrent count is held at zero, so any length of overcurrent run produces no hiccup.
- R4: With the channel armed, UV_LIM (8) consecutive undervoltage cycles raise `hiccup[i]` in the same way, and a cycle without undervoltage restarts that count. While `ss_done[i]` is low and the channel is not latched, undervoltage is not counted.
- R5: `low_force[i]` equals `ov_hit[i]` in the same cycle, except while `gate_hiz[i]` is set.
- R6: With the channel armed, OV_LIM (32) consecutive overvoltage cycles set `gate_hiz[i]` after the edge that sampled the last of them. That edge fires no hiccup, so the ramp is left charged. While the latch holds, `low_force[i]` stays low.
- R7: `hiccup[i]` is high for exactly one cycle. After it, the channel stays disarmed and ignores fault runs until `ss_done[i]` has been sampled low and then high again.
- R8: When `ch_off[i]` is sampled high, `gate_hiz[i]` clears on that edge, the fault counts are held at zero, and no hiccup is produced while it stays high.
- R9: While `gate_hiz[i]` is set, UV_LIM consecutive undervoltage cycles clear the latch and raise `hiccup[i]` on the same edge.
- R10: During reset, `gate_hiz` and `hiccup` are low. Channels are independent, so faults on one channel never move the outputs of another. Bit i of every vector port belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM cycle clock |
| rst_n | input | 1 | Active-low reset (power recycle) |
| oc_hit | input | NCH | Overcurrent seen while the high-side switch was on, per channel |
| uv_hit | input | NCH | Feedback at or below the undervoltage threshold, per channel |
| ov_hit | input | NCH | Feedback at or above the overvoltage threshold, per channel |
| ss_done | input | NCH | Soft-start ramp complete, per channel |
| ch_off | input | NCH | External disable, per channel |
| pulse_cut | output | NCH | End the high-side pulse now |
| low_force | output | NCH | Hold the low-side switch on |
| gate_hiz | output | NCH | Both gates latched high impedance |
| hiccup | output | NCH | One-cycle request to discharge and restart the soft-start ramp |

## Verification
The bench probes the thresholds from both sides. It runs each fault for one cycle fewer than its limit, breaks the run with a single clean cycle, and then runs it for the full limit. A counter that did not restart on a clean cycle would fire early, and an off-by-one compare would fire a cycle too soon or too late. Overcurrent and undervoltage runs are also applied during soft-start, and long overcurrent runs are applied just after a hiccup. These catch a counter that is not held in reset and a re-arm that does not wait for the ramp to restart, both of which would show up as extra hiccups. The overvoltage latch is driven out through both of its exits. A design that discharged the ramp on latching, or that cleared the latch without firing a hiccup on the undervoltage exit, shows a wrong `hiccup` or `gate_hiz` value on the exact cycle being checked.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  // Bits needed to hold a count from 0 up to lim inclusive.
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Comparator results and control flags for one channel, for one PWM cycle.
  typedef struct packed {
    logic oc;
    logic uv;
    logic ov;
    logic ss_done;
    logic off;
  } hcp_sense_t;

endpackage

// File: rtl/hcp_run_counter.sv
module hcp_run_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  output logic reached
);
  localparam int W = hcp_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] TOP  = W'(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] count;
  logic [W-1:0] count_nxt;
  logic         live;

  // Add one, but stop at the terminal count instead of wrapping.
  function automatic logic [W-1:0] sat_step(input logic [W-1:0] c);
    if (c >= TOP) return TOP;
    return c + 1'b1;
  endfunction

  assign live      = en && hit;
  assign count_nxt = live ? sat_step(count) : '0;
  // Fire only on the step into the terminal count, never while parked there.
  assign reached   = live && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  a_r2_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP);

  a_r2_miss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (count == '0));

endmodule

// File: rtl/hcp_arm_gate.sv
module hcp_arm_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_done,
  input  logic off,
  input  logic fire,
  output logic armed
);
  logic waiting;

  // After a hiccup, stay disarmed until the ramp is seen low, then let it come back.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        waiting <= 1'b0;
    else if (fire)     waiting <= 1'b1;
    else if (!ss_done) waiting <= 1'b0;
  end

  assign armed = ss_done && !waiting && !off;

  a_r7_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

endmodule

// File: rtl/hcp_channel.sv
module hcp_channel #(
  parameter int OC_LIM = 32,
  parameter int UV_LIM = 8,
  parameter int OV_LIM = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  hcp_pkg::hcp_sense_t sense,
  output logic               pulse_cut,
  output logic               low_force,
  output logic               gate_hiz,
  output logic               hiccup
);
  logic armed;
  logic oc_en, uv_en, ov_en;
  logic oc_reached, uv_reached, ov_reached;
  logic fire, latch_set, latch_clr;

  // Overcurrent and overvoltage runs count only while armed and not latched.
  // Undervoltage also counts while latched, because that is the latch's exit path.
  assign oc_en = armed && !gate_hiz;
  assign ov_en = armed && !gate_hiz;
  assign uv_en = (armed || gate_hiz) && !sense.off;

  hcp_run_counter #(.LIMIT(OC_LIM)) u_oc_run (
    .clk(clk), .rst_n(rst_n), .en(oc_en), .hit(sense.oc), .reached(oc_reached));

  hcp_run_counter #(.LIMIT(UV_LIM)) u_uv_run (
    .clk(clk), .rst_n(rst_n), .en(uv_en), .hit(sense.uv), .reached(uv_reached));

  hcp_run_counter #(.LIMIT(OV_LIM)) u_ov_run (
    .clk(clk), .rst_n(rst_n), .en(ov_en), .hit(sense.ov), .reached(ov_reached));

  hcp_arm_gate u_arm (
    .clk(clk), .rst_n(rst_n), .ss_done(sense.ss_done), .off(sense.off),
    .fire(fire), .armed(armed));

  assign fire      = !sense.off && (oc_reached || uv_reached);
  assign latch_set = ov_reached && !fire;
  assign latch_clr = sense.off || (gate_hiz && uv_reached);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hiz <= 1'b0;
      hiccup   <= 1'b0;
    end else begin
      hiccup <= fire;
      if (latch_clr)      gate_hiz <= 1'b0;
      else if (latch_set) gate_hiz <= 1'b1;
    end
  end

  // Same-cycle actions, with no register in the path.
  assign pulse_cut = sense.oc;
  assign low_force = sense.ov && !gate_hiz;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup |=> !hiccup);

  a_r6_latch_keeps_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hiz) |-> !hiccup);

  a_r6_latched_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hiz |-> !low_force);

  a_r8_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
    sense.off |=> (!gate_hiz && !hiccup));

  a_r3_softstart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense.ss_done && !gate_hiz) |=> !hiccup);

endmodule

// File: rtl/fault_hiccup_ctl.sv
module fault_hiccup_ctl #(
  parameter int NCH    = 2,
  parameter int OC_LIM = 32,
  parameter int UV_LIM = 8,
  parameter int OV_LIM = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] oc_hit,
  input  logic [NCH-1:0] uv_hit,
  input  logic [NCH-1:0] ov_hit,
  input  logic [NCH-1:0] ss_done,
  input  logic [NCH-1:0] ch_off,
  output logic [NCH-1:0] pulse_cut,
  output logic [NCH-1:0] low_force,
  output logic [NCH-1:0] gate_hiz,
  output logic [NCH-1:0] hiccup
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    hcp_pkg::hcp_sense_t sense;

    assign sense.oc      = oc_hit[ch];
    assign sense.uv      = uv_hit[ch];
    assign sense.ov      = ov_hit[ch];
    assign sense.ss_done = ss_done[ch];
    assign sense.off     = ch_off[ch];

    hcp_channel #(.OC_LIM(OC_LIM), .UV_LIM(UV_LIM), .OV_LIM(OV_LIM)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .sense     (sense),
      .pulse_cut (pulse_cut[ch]),
      .low_force (low_force[ch]),
      .gate_hiz  (gate_hiz[ch]),
      .hiccup    (hiccup[ch])
    );
  end

endmodule

// File: tb/fault_hiccup_ctl_test.sv
module fault_hiccup_ctl_test;
  localparam int NCH = 2;
  localparam int OCL = 32;
  localparam int UVL = 8;
  localparam int OVL = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] oc, uv, ov, ss, xo;
  logic [NCH-1:0] pc, lf, hz, hc;

  int n_cmp = 0;
  int n_bad = 0;
  bit ch1_bad = 1'b0;
  bit seen;

  fault_hiccup_ctl #(.NCH(NCH), .OC_LIM(OCL), .UV_LIM(UVL), .OV_LIM(OVL)) uut (
    .clk(clk), .rst_n(rst_n), .oc_hit(oc), .uv_hit(uv), .ov_hit(ov),
    .ss_done(ss), .ch_off(xo), .pulse_cut(pc), .low_force(lf),
    .gate_hiz(hz), .hiccup(hc));

  always #4 clk = ~clk;

  // R10: channel 1 is held idle and must never move.
  always @(negedge clk) if (rst_n === 1'b1 && (hc[1] | hz[1] | lf[1])) ch1_bad = 1'b1;

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive channel 0 for one PWM cycle, then sample after the edge.
  task automatic cyc(input logic o, input logic u, input logic v, input logic s, input logic x);
    oc[0] = o; uv[0] = u; ov[0] = v; ss[0] = s; xo[0] = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    oc = '0; uv = '0; ov = '0; xo = '0; ss = '1; ss[0] = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset hiccup", hc[0], 1'b0);
    check("R10 reset gate_hiz", hz[0], 1'b0);
    rst_n = 1'b1;

    // R1: immediate pulse cut, in and out of soft-start
    oc[0] = 1'b1; #1 check("R1 cut in soft-start", pc[0], 1'b1);
    oc[0] = 1'b0; #1 check("R1 cut released", pc[0], 1'b0);
    ss[0] = 1'b1; oc[0] = 1'b1; #1 check("R1 cut after soft-start", pc[0], 1'b1);
    oc[0] = 1'b0; ss[0] = 1'b0;

    // R3: overcurrent during soft-start never hiccups
    seen = 1'b0;
    repeat (40) begin cyc(1, 0, 0, 0, 0); seen |= hc[0]; end
    check("R3 no hiccup in soft-start", seen, 1'b0);

    // R2: limit-1 run, break, then full run
    seen = 1'b0;
    for (int i = 1; i < OCL; i++) begin cyc(1, 0, 0, 1, 0); seen |= hc[0]; end
    check("R2 short run quiet", seen, 1'b0);
    cyc(0, 0, 0, 1, 0);
    check("R2 break cycle quiet", hc[0], 1'b0);
    for (int i = 1; i <= OCL; i++) begin
      cyc(1, 0, 0, 1, 0);
      check("R2 oc run", hc[0], i == OCL);
    end

    // R7: one-cycle pulse, then disarmed until ramp restarts
    cyc(1, 0, 0, 1, 0);
    check("R7 pulse ends", hc[0], 1'b0);
    seen = 1'b0;
    repeat (40) begin cyc(1, 0, 0, 1, 0); seen |= hc[0]; end
    check("R7 disarmed", seen, 1'b0);
    cyc(0, 0, 0, 0, 0);
    for (int i = 1; i <= OCL; i++) begin
      cyc(1, 0, 0, 1, 0);
      check("R7 rearmed run", hc[0], i == OCL);
    end
    cyc(0, 0, 0, 0, 0);

    // R4: undervoltage runs
    for (int i = 1; i < UVL; i++) begin
      cyc(0, 1, 0, 1, 0);
      check("R4 uv short run", hc[0], 1'b0);
    end
    cyc(0, 0, 0, 1, 0);
    for (int i = 1; i <= UVL; i++) begin
      cyc(0, 1, 0, 1, 0);
      check("R4 uv run", hc[0], i == UVL);
    end
    cyc(0, 0, 0, 0, 0);
    seen = 1'b0;
    repeat (20) begin cyc(0, 1, 0, 0, 0); seen |= hc[0]; end
    check("R4 uv ignored in soft-start", seen, 1'b0);

    // R5 / R6: overvoltage forces low side, then latches
    ss[0] = 1'b1; uv[0] = 1'b0; ov[0] = 1'b1;
    #1 check("R5 low force immediate", lf[0], 1'b1);
    for (int i = 1; i <= OVL; i++) begin
      cyc(0, 0, 1, 1, 0);
      check("R6 latch timing", hz[0], i >= OVL);
      check("R5 low force until latch", lf[0], i < OVL);
      check("R6 no hiccup on latch", hc[0], 1'b0);
    end
    repeat (5) begin
      cyc(0, 0, 1, 1, 0);
      check("R6 latch holds", hz[0], 1'b1);
      check("R6 low force off while latched", lf[0], 1'b0);
    end

    // R8: external off clears the latch and blocks hiccups
    cyc(0, 0, 1, 1, 1);
    check("R8 off clears latch", hz[0], 1'b0);
    check("R8 off no hiccup", hc[0], 1'b0);
    seen = 1'b0;
    repeat (40) begin cyc(1, 0, 0, 1, 1); seen |= hc[0] | hz[0]; end
    check("R8 off blocks faults", seen, 1'b0);
    cyc(0, 0, 0, 1, 0);

    // R9: latch exit through undervoltage
    for (int i = 1; i <= OVL; i++) cyc(0, 0, 1, 1, 0);
    check("R9 relatched", hz[0], 1'b1);
    for (int i = 1; i < UVL; i++) begin
      cyc(0, 1, 0, 1, 0);
      check("R9 short uv keeps latch", hz[0], 1'b1);
      check("R9 short uv quiet", hc[0], 1'b0);
    end
    cyc(0, 0, 0, 1, 0);
    check("R9 break keeps latch", hz[0], 1'b1);
    for (int i = 1; i <= UVL; i++) begin
      cyc(0, 1, 0, 1, 0);
      check("R9 uv exit hiccup", hc[0], i == UVL);
      check("R9 uv exit latch", hz[0], i < UVL);
    end
    cyc(0, 0, 0, 0, 0);

    check("R10 channel 1 untouched", ch1_bad, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule